// File: doc/BRIEF.md
# Bidirectional Latched Inverting Transceiver

This block joins two eight-bit buses, A and B, through two independent storage paths: one carries data from A to B and the other from B to A. Each path has its own active-low chip enable, latch enable and output enable. The chip enable gates both loading and driving for its direction. The latch enable chooses between following the source bus and holding the captured byte. The output enable, together with the chip enable, decides whether the far port is driven.

The driven value is always the bitwise complement of the stored byte, in both directions. Each port is presented as separate input, output and drive-enable signals, with no internal tri-states. The storage is a clock-synchronous stand-in for a level latch: while open it reloads on every clock, and when it closes it keeps the byte from the last open cycle. An integrating wrapper may add pad buffers.

Top module: `xcvr_latched_inv`

## Requirements
- R1: While `rst_ni` is low, both drive enables `a_oe_o` and `b_oe_o` are 0 and both stores are cleared to zero, so `b_o` and `a_o` read 8'hFF. The clear holds until the first load after release.
- R2: When a direction's chip enable is high, its store keeps its value on every clock, whatever its latch enable and source bus do.
- R3: When a direction's chip enable and latch enable are both low at a rising clock edge, the store loads the source bus on that edge. The output reflects it from then on.
- R4: When a direction's latch enable is high at a clock edge, the store keeps the byte captured in the last cycle in which it was open.
- R5: A port's drive enable is 1 exactly when reset is released and both the chip enable and the output enable of the direction driving that port are low. `b_oe_o` follows the A-to-B controls and `a_oe_o` follows the B-to-A controls.
- R6: A port's data output is always the bitwise complement of the byte held in the store that feeds it: `b_o` = ~(A-to-B store) and `a_o` = ~(B-to-A store).
- R7: The two directions are independent. The A-to-B controls and `a_i` never affect `a_o` or `a_oe_o`, and the B-to-A controls and `b_i` never affect `b_o` or `b_oe_o`.
- R8: The output enable has no effect on storage. Toggling it with the latch closed leaves the data output unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| a_i | input | 8 | Bus A as seen at its pads (source for A-to-B) |
| a_o | output | 8 | Data driven onto bus A (B-to-A result) |
| a_oe_o | output | 1 | Drive enable for bus A |
| b_i | input | 8 | Bus B as seen at its pads (source for B-to-A) |
| b_o | output | 8 | Data driven onto bus B (A-to-B result) |
| b_oe_o | output | 1 | Drive enable for bus B |
| ab_ce_ni | input | 1 | A-to-B chip enable, active low |
| ab_le_ni | input | 1 | A-to-B latch enable, active low |
| ab_oe_ni | input | 1 | A-to-B output enable, active low |
| ba_ce_ni | input | 1 | B-to-A chip enable, active low |
| ba_le_ni | input | 1 | B-to-A latch enable, active low |
| ba_oe_ni | input | 1 | B-to-A output enable, active low |

## Verification
The source buses are changed every cycle while the latch is open and again after it closes. This separates a store that follows its input from one that holds the byte from the last open cycle. Runs where the chip enable is high but the latch enable is low show whether the chip enable really gates loading. Runs of random control combinations on both directions at once, with unrelated data on each bus, expose any cross-coupling between the paths and any inversion or enable-decode error. A mid-run reset checks the clear and the tri-state condition.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
  localparam int unsigned NUM_DIR = 2;
  localparam int unsigned DIR_AB  = 0;
  localparam int unsigned DIR_BA  = 1;

  typedef struct packed {
    logic ce_n;
    logic le_n;
    logic oe_n;
  } dir_ctrl_t;
endpackage

// File: rtl/xcvr_store.sv
module xcvr_store #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         ce_ni,
  input  logic         le_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic open_q;
  assign open_q = ~ce_ni & ~le_ni;

  // transparent phase reloads each clock; closing keeps last open sample
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_o <= '0;
    else if (open_q) q_o <= d_i;
  end
endmodule

// File: rtl/xcvr_drive.sv
module xcvr_drive #(
  parameter int unsigned W      = 8,
  parameter bit          INVERT = 1'b1
) (
  input  logic         rst_ni,
  input  logic         ce_ni,
  input  logic         oe_ni,
  input  logic [W-1:0] q_i,
  output logic [W-1:0] y_o,
  output logic         en_o
);
  generate
    if (INVERT) begin : g_inv
      assign y_o = ~q_i;
    end else begin : g_buf
      assign y_o = q_i;
    end
  endgenerate

  assign en_o = rst_ni & ~ce_ni & ~oe_ni;
endmodule

// File: rtl/xcvr_path.sv
module xcvr_path
  import xcvr_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  dir_ctrl_t    ctrl_i,
  input  logic [W-1:0] src_i,
  output logic [W-1:0] dst_o,
  output logic         dst_en_o
);
  logic [W-1:0] held;

  xcvr_store #(.W(W)) u_store (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .ce_ni (ctrl_i.ce_n),
    .le_ni (ctrl_i.le_n),
    .d_i   (src_i),
    .q_o   (held)
  );

  xcvr_drive #(.W(W), .INVERT(1'b1)) u_drive (
    .rst_ni(rst_ni),
    .ce_ni (ctrl_i.ce_n),
    .oe_ni (ctrl_i.oe_n),
    .q_i   (held),
    .y_o   (dst_o),
    .en_o  (dst_en_o)
  );
endmodule

// File: rtl/xcvr_latched_inv.sv
module xcvr_latched_inv
  import xcvr_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] a_i,
  output logic [W-1:0] a_o,
  output logic         a_oe_o,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] b_o,
  output logic         b_oe_o,
  input  logic         ab_ce_ni,
  input  logic         ab_le_ni,
  input  logic         ab_oe_ni,
  input  logic         ba_ce_ni,
  input  logic         ba_le_ni,
  input  logic         ba_oe_ni
);
  dir_ctrl_t    ctrl [NUM_DIR];
  logic [W-1:0] src  [NUM_DIR];
  logic [W-1:0] dst  [NUM_DIR];
  logic         den  [NUM_DIR];

  assign ctrl[DIR_AB] = '{ce_n: ab_ce_ni, le_n: ab_le_ni, oe_n: ab_oe_ni};
  assign ctrl[DIR_BA] = '{ce_n: ba_ce_ni, le_n: ba_le_ni, oe_n: ba_oe_ni};
  assign src[DIR_AB]  = a_i;
  assign src[DIR_BA]  = b_i;

  generate
    for (genvar d = 0; d < NUM_DIR; d++) begin : g_dir
      xcvr_path #(.W(W)) u_path (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .ctrl_i  (ctrl[d]),
        .src_i   (src[d]),
        .dst_o   (dst[d]),
        .dst_en_o(den[d])
      );
    end
  endgenerate

  assign b_o    = dst[DIR_AB];
  assign b_oe_o = den[DIR_AB];
  assign a_o    = dst[DIR_BA];
  assign a_oe_o = den[DIR_BA];
endmodule

// File: rtl/xcvr_latched_inv_chk.sv
module xcvr_latched_inv_chk #(
  parameter int unsigned W = 8
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic [W-1:0] a_i,
  input logic [W-1:0] a_o,
  input logic         a_oe_o,
  input logic [W-1:0] b_i,
  input logic [W-1:0] b_o,
  input logic         b_oe_o,
  input logic         ab_ce_ni,
  input logic         ab_le_ni,
  input logic         ab_oe_ni,
  input logic         ba_ce_ni,
  input logic         ba_le_ni,
  input logic         ba_oe_ni
);
  always @(negedge clk_i) begin
    if (!rst_ni) begin
      AST_RST_NO_DRIVE: assert (!a_oe_o && !b_oe_o); // R1
    end
  end

  AST_AB_CE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ab_ce_ni |=> $stable(b_o)); // R2
  AST_BA_CE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ba_ce_ni |=> $stable(a_o)); // R7
  AST_AB_LOAD_INV: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ab_ce_ni && !ab_le_ni) |=> (b_o == ~$past(a_i))); // R3
  AST_BA_LOAD_INV: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ba_ce_ni && !ba_le_ni) |=> (a_o == ~$past(b_i))); // R6
  AST_AB_LE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ab_le_ni |=> $stable(b_o)); // R4
  AST_AB_CE_TRISTATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ab_ce_ni || ab_oe_ni) |-> !b_oe_o); // R5
  AST_BA_CE_TRISTATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ba_ce_ni || ba_oe_ni) |-> !a_oe_o); // R5
endmodule

bind xcvr_latched_inv xcvr_latched_inv_chk #(.W(W)) u_chk (.*);

// File: tb/tb_xcvr_latched_inv.sv
`timescale 1ns/1ps
module tb_xcvr_latched_inv;
  localparam int W = 8;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic [W-1:0] a_i = '0, b_i = '0;
  logic [W-1:0] a_o, b_o;
  logic         a_oe_o, b_oe_o;
  logic ab_ce_ni = 1'b1, ab_le_ni = 1'b1, ab_oe_ni = 1'b1;
  logic ba_ce_ni = 1'b1, ba_le_ni = 1'b1, ba_oe_ni = 1'b1;

  int n_cmp = 0;
  int n_bad = 0;
  int ab_store = 0;
  int ba_store = 0;
  bit done = 1'b0;

  always #2 clk_i = ~clk_i;

  xcvr_latched_inv #(.W(W)) dut (.*);

  task automatic chk(string tag, string what, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, exp);
    end
  endtask

  // one clock: model update at posedge, compare at negedge
  task automatic step(string tag);
    @(posedge clk_i);
    if (!rst_ni) begin
      ab_store = 0;
      ba_store = 0;
    end else begin
      if (!ab_ce_ni && !ab_le_ni) ab_store = int'(a_i);
      if (!ba_ce_ni && !ba_le_ni) ba_store = int'(b_i);
    end
    @(negedge clk_i);
    chk(tag, "b_o", int'(b_o), (~ab_store) & 8'hFF);
    chk(tag, "a_o", int'(a_o), (~ba_store) & 8'hFF);
    chk(tag, "b_oe_o", int'(b_oe_o), int'(rst_ni && !ab_ce_ni && !ab_oe_ni));
    chk(tag, "a_oe_o", int'(a_oe_o), int'(rst_ni && !ba_ce_ni && !ba_oe_ni));
  endtask

  initial begin
    #(200000 * 4);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    @(negedge clk_i);
    ab_ce_ni = 1'b0; ab_le_ni = 1'b0; ab_oe_ni = 1'b0;
    ba_ce_ni = 1'b0; ba_le_ni = 1'b0; ba_oe_ni = 1'b0;
    a_i = 8'h5A; b_i = 8'hC3;
    step("R1");
    step("R1");
    rst_ni = 1'b1;
    ab_ce_ni = 1'b1; ba_ce_ni = 1'b1;
    step("R1");

    // R3/R6: open A-to-B, walk patterns
    ab_ce_ni = 1'b0; ab_le_ni = 1'b0; ab_oe_ni = 1'b0;
    for (int i = 0; i < W; i++) begin
      a_i = 8'(1 << i);
      step("R3");
    end
    a_i = 8'hFF; step("R6");
    a_i = 8'h00; step("R6");
    a_i = 8'hA5; step("R6");

    // R4: close latch, then change input
    ab_le_ni = 1'b1;
    a_i = 8'h3C; step("R4");
    a_i = 8'h81; step("R4");

    // R8: toggle output enable while closed
    ab_oe_ni = 1'b1; step("R8");
    a_i = 8'h18; step("R8");
    ab_oe_ni = 1'b0; step("R8");

    // R2: chip enable high with latch open
    ab_ce_ni = 1'b1; ab_le_ni = 1'b0;
    a_i = 8'h77; step("R2");
    a_i = 8'h11; step("R2");

    // R5: enable decode
    ab_ce_ni = 1'b0; ab_oe_ni = 1'b1; step("R5");
    ab_ce_ni = 1'b1; ab_oe_ni = 1'b0; step("R5");
    ab_ce_ni = 1'b0; ab_oe_ni = 1'b0; step("R5");

    // R7: B-to-A path alone, A-to-B closed and disabled
    ab_ce_ni = 1'b1;
    ba_ce_ni = 1'b0; ba_le_ni = 1'b0; ba_oe_ni = 1'b0;
    b_i = 8'h96; a_i = 8'h0F; step("R7");
    ba_le_ni = 1'b1; b_i = 8'h69; step("R7");
    ba_ce_ni = 1'b1; ba_le_ni = 1'b0; b_i = 8'hE1; step("R7");

    // R7: random controls on both directions
    for (int i = 0; i < 300; i++) begin
      {ab_ce_ni, ab_le_ni, ab_oe_ni} = 3'($urandom);
      {ba_ce_ni, ba_le_ni, ba_oe_ni} = 3'($urandom);
      a_i = 8'($urandom);
      b_i = 8'($urandom);
      step("R7");
    end

    // R1: mid-run reset
    rst_ni = 1'b0;
    ab_ce_ni = 1'b0; ab_oe_ni = 1'b0; ba_ce_ni = 1'b0; ba_oe_ni = 1'b0;
    step("R1");
    rst_ni = 1'b1;
    ab_le_ni = 1'b1; ba_le_ni = 1'b1;
    step("R1");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule